// File: doc/BRIEF.md
# Broadcast Data Line Deframer

This block sits after a bit-clock recovery stage on a data line carried in the video blanking interval. It receives one recovered bit per strobe and a pulse at the start of every line. It first hunts for an eight-bit framing pattern that follows the clock run-in. When it finds the pattern, it cuts the rest of the line into 42 payload bytes. Each byte is decoded according to its position in the line and delivered on a one-cycle valid strobe, together with its index, the decoded value and error flags.

The first payload bytes (two by default) carry a four-bit value protected by a single-error-correcting, double-error-detecting code. The remaining bytes carry seven data bits and an odd-parity bit. The hunt is accepted only within a bounded number of strobes after the line start. If the pattern does not appear in that span, the line is dropped. The block then ignores all bits until the next line start.

Top module: `line_deframer`

## Requirements
- R1: After reset all outputs are zero and the block ignores every bit, including a complete framing pattern, until the first `line_start` pulse.
- R2: After `line_start` the block compares the last eight strobed bits against the framing pattern, which in arrival order is 1,1,1,0,0,1,0,0. The strobe that follows the last framing bit carries payload bit 0.
- R3: A match counts only if the last framing bit is at most strobe `SEARCH_BITS` (default 32) after `line_start`, counting from 1. If there is no such match, the line is abandoned and produces no bytes.
- R4: Payload bytes are assembled least-significant bit first: the first bit of a byte to arrive becomes bit 0.
- R5: `byte_vld` pulses for exactly one cycle, in the cycle after the strobe that carries a byte's eighth bit. `byte_idx` counts payload bytes 0, 1, 2 … in order. All data and flag outputs are zero while `byte_vld` is low.
- R6: Header bytes (index below `HDR_BYTES`, default 2) have the layout bit0=d0, bit1=c0, bit2=d1, bit3=c1, bit4=d2, bit5=c2, bit6=d3, bit7=p. The check bits are c0=d0^d1^d3, c1=d0^d2^d3 and c2=d1^d2^d3, and p makes the total count of ones odd. An intact header byte yields `byte_data` = {4'b0, d3, d2, d1, d0} with all flags low.
- R7: A header byte with any single flipped bit (including p) yields the original nibble with `ham_cor` high and `ham_unc` low.
- R8: A header byte with two flipped bits yields `ham_unc` high, `ham_cor` low, and `byte_data` = {4'b0, bit6, bit4, bit2, bit0} of the received byte.
- R9: A text byte (index `HDR_BYTES` and above) yields `byte_data` = {1'b0, received bits 6..0}. `par_err` is high exactly when the received byte has an even number of ones. Text bytes never raise the header flags.
- R10: After payload byte index 41 the block ignores further bits until the next `line_start`.
- R11: A `line_start` pulse in any state abandons the current line and starts a new hunt.
- R12: `bit_in` is ignored in cycles where `bit_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of every line |
| bit_stb | input | 1 | High in cycles that carry a recovered bit |
| bit_in | input | 1 | Recovered bit, valid with `bit_stb` |
| byte_vld | output | 1 | One-cycle strobe for a decoded payload byte |
| byte_idx | output | 6 | Payload byte index, 0 to 41 |
| byte_data | output | 8 | Decoded nibble (header) or seven data bits (text) |
| par_err | output | 1 | Odd-parity failure on a text byte |
| ham_cor | output | 1 | Header byte held a single error that was corrected |
| ham_unc | output | 1 | Header byte held an uncorrectable double error |

## Verification
Some properties are checked on every cycle:
- the single-cycle shape of the valid strobe and that it follows a strobed bit;
- the index range;
- that the header and text flags stay separate, and that outputs are quiet between bytes;
- silence before the first line start and right after any line start.

The correctness of the decoded values, error correction of every bit position, and acceptance or rejection at the edge of the search window can only be shown by the bench's lines. The same holds for the exact byte count per line and the cut-off after the last byte. Those lines have random spacing between strobes, random payloads and injected errors.

// File: rtl/line_deframer_pkg.sv
// Shared types for the line deframer.
// Assumes: none beyond IEEE 1800-2017 packed types.
package line_deframer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_PAYLOAD = 2'd2
    } dfm_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       ham_cor;
        logic       ham_unc;
    } dfm_result_t;

endpackage

// File: rtl/frame_hunt.sv
// Framing-pattern hunter.
// Keeps a sliding window of the last eight strobed bits, newest bit in the
// MSB, and a count of strobes since the last clear. It reports a hit when the
// window equals CODE within the first SEARCH_BITS strobes, and an expiry when
// the count reaches SEARCH_BITS without a hit.
// Assumes: SEARCH_BITS >= 8; the caller stops enabling once hit or expired.
module frame_hunt #(
    parameter int         SEARCH_BITS = 32,
    parameter logic [7:0] CODE        = 8'h27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic bit_in,
    output logic hit,
    output logic expired
);
    localparam int CW = $clog2(SEARCH_BITS + 1);

    logic [7:0]    win_q, win_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // Next window and count as if this strobe is taken.
    always_comb begin
        win_n   = {bit_in, win_q[7:1]};
        cnt_n   = cnt_q + 1'b1;
        hit     = enable && (win_n == CODE) &&
                  (cnt_n >= CW'(8)) && (cnt_n <= CW'(SEARCH_BITS));
        expired = enable && !hit && (cnt_n >= CW'(SEARCH_BITS));
    end

    // Window and count registers, cleared at every line start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (enable) begin
            win_q <= win_n;
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/byte_shifter.sv
// LSB-first byte assembler.
// Shifts strobed bits into the MSB, so the first bit to arrive ends in bit 0.
// It raises full in the cycle that takes the last bit, with the finished word.
// Assumes: clear has priority over shift.
module byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         bit_in,
    output logic         full,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    // Completed word and full flag for the current strobe.
    always_comb begin
        word = {bit_in, sr_q[W-1:1]};
        full = shift && (cnt_q == CW'(W - 1));
    end

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift) begin
            sr_q  <= word;
            cnt_q <= full ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/byte_decode.sv
// Combinational byte decoder.
// Header bytes: layout d0,c0,d1,c1,d2,c2,d3,p from bit 0 up, with odd overall
// parity. Single errors are corrected and double errors are flagged.
// Text bytes: seven data bits plus an odd-parity bit in bit 7.
// Assumes: raw is assembled LSB first.
module byte_decode
    import line_deframer_pkg::*;
(
    input  logic [7:0]  raw,
    input  logic        is_hdr,
    output dfm_result_t res
);
    logic [3:0] nib;
    logic [2:0] syn;
    logic [3:0] fix;
    logic       odd_ok;

    // Syndrome over the three check groups and the overall parity.
    always_comb begin
        nib    = {raw[6], raw[4], raw[2], raw[0]};
        syn[0] = raw[1] ^ raw[0] ^ raw[2] ^ raw[6];
        syn[1] = raw[3] ^ raw[0] ^ raw[4] ^ raw[6];
        syn[2] = raw[5] ^ raw[2] ^ raw[4] ^ raw[6];
        odd_ok = ^raw;
        unique case (syn)
            3'b011:  fix = 4'b0001;
            3'b101:  fix = 4'b0010;
            3'b110:  fix = 4'b0100;
            3'b111:  fix = 4'b1000;
            default: fix = 4'b0000;
        endcase
    end

    // Choose the result according to the byte's kind.
    always_comb begin
        res = '0;
        if (is_hdr) begin
            if (!odd_ok) begin
                res.data    = {4'b0, nib ^ fix};
                res.ham_cor = 1'b1;
            end else if (syn != 3'b000) begin
                res.data    = {4'b0, nib};
                res.ham_unc = 1'b1;
            end else begin
                res.data    = {4'b0, nib};
            end
        end else begin
            res.data    = {1'b0, raw[6:0]};
            res.par_err = !odd_ok;
        end
    end

endmodule

// File: rtl/line_deframer.sv
// Line deframer top.
// Line flow: line_start opens a hunt for the framing pattern. A hit moves to
// payload assembly. PAYLOAD_BYTES bytes are decoded and registered onto the
// outputs, then the block idles until the next line_start.
// Assumes: bit_stb is at most one per cycle; line_start overrides a strobe.
module line_deframer
    import line_deframer_pkg::*;
#(
    parameter int         SEARCH_BITS   = 32,
    parameter int         PAYLOAD_BYTES = 42,
    parameter int         HDR_BYTES     = 2,
    parameter logic [7:0] FRAME_CODE    = 8'h27,
    localparam int        IW            = $clog2(PAYLOAD_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          bit_stb,
    input  logic          bit_in,
    output logic          byte_vld,
    output logic [IW-1:0] byte_idx,
    output logic [7:0]    byte_data,
    output logic          par_err,
    output logic          ham_cor,
    output logic          ham_unc
);
    localparam logic [IW-1:0] LAST_IDX = IW'(PAYLOAD_BYTES - 1);
    localparam logic [IW-1:0] HDR_LIM  = IW'(HDR_BYTES);

    dfm_state_e    state_q;
    logic [IW-1:0] cnt_q;
    logic          hunt_en, hit, expired;
    logic          shift_en, full;
    logic [7:0]    word;
    dfm_result_t   res;

    assign hunt_en  = bit_stb && !line_start && (state_q == ST_HUNT);
    assign shift_en = bit_stb && !line_start && (state_q == ST_PAYLOAD);

    frame_hunt #(
        .SEARCH_BITS (SEARCH_BITS),
        .CODE        (FRAME_CODE)
    ) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (line_start),
        .enable  (hunt_en),
        .bit_in  (bit_in),
        .hit     (hit),
        .expired (expired)
    );

    byte_shifter #(
        .W (8)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (line_start || hit),
        .shift  (shift_en),
        .bit_in (bit_in),
        .full   (full),
        .word   (word)
    );

    byte_decode u_dec (
        .raw    (word),
        .is_hdr (cnt_q < HDR_LIM),
        .res    (res)
    );

    // Line state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (line_start) begin
            state_q <= ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT:    if (hit) state_q <= ST_PAYLOAD;
                            else if (expired) state_q <= ST_IDLE;
                ST_PAYLOAD: if (full && cnt_q == LAST_IDX) state_q <= ST_IDLE;
                default:    state_q <= state_q;
            endcase
        end
    end

    // Payload byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start || hit) cnt_q <= '0;
        else if (full)                   cnt_q <= cnt_q + 1'b1;
    end

    // Registered outputs: one strobe per finished byte, quiet otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !full) begin
            byte_vld  <= 1'b0;
            byte_idx  <= '0;
            byte_data <= '0;
            par_err   <= 1'b0;
            ham_cor   <= 1'b0;
            ham_unc   <= 1'b0;
        end else begin
            byte_vld  <= 1'b1;
            byte_idx  <= cnt_q;
            byte_data <= res.data;
            par_err   <= res.par_err;
            ham_cor   <= res.ham_cor;
            ham_unc   <= res.ham_unc;
        end
    end

endmodule

// File: rtl/line_deframer_chk.sv
// Cycle-level property checker for line_deframer, bound to every instance.
// Assumes: the same parameter values as the instance it is bound to.
module line_deframer_chk #(
    parameter int PAYLOAD_BYTES = 42,
    parameter int HDR_BYTES     = 2,
    parameter int IW            = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic          bit_stb,
    input logic          byte_vld,
    input logic [IW-1:0] byte_idx,
    input logic [7:0]    byte_data,
    input logic          par_err,
    input logic          ham_cor,
    input logic          ham_unc
);
    logic seen_start;

    // Remember whether any line has started since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_start <= 1'b0;
        else if (line_start) seen_start <= 1'b1;
    end

    p_silent_before_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> seen_start);

    p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    p_vld_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_stb));

    p_quiet_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> (byte_data == 8'h00 && !par_err && !ham_cor && !ham_unc));

    p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (int'(byte_idx) < PAYLOAD_BYTES));

    p_hdr_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && int'(byte_idx) < HDR_BYTES) |-> (byte_data[7:4] == 4'h0 && !par_err));

    p_ham_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ham_cor && ham_unc));

    p_text_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && int'(byte_idx) >= HDR_BYTES) |-> (!ham_cor && !ham_unc && !byte_data[7]));

    p_restart_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !byte_vld);

endmodule

bind line_deframer line_deframer_chk #(
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .HDR_BYTES     (HDR_BYTES),
    .IW            (IW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .bit_stb    (bit_stb),
    .byte_vld   (byte_vld),
    .byte_idx   (byte_idx),
    .byte_data  (byte_data),
    .par_err    (par_err),
    .ham_cor    (ham_cor),
    .ham_unc    (ham_unc)
);

// File: tb/sim_line_deframer.sv
// Bench for line_deframer: random lines with directed corner cases.
module sim_line_deframer;
    localparam int NB = 42;
    localparam logic [7:0] CODE = 8'h27;  // arrival order 1,1,1,0,0,1,0,0

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_in = 1'b0;
    logic       byte_vld;
    logic [5:0] byte_idx;
    logic [7:0] byte_data;
    logic       par_err, ham_cor, ham_unc;

    int n_chk = 0;
    int n_bad = 0;
    int got_cnt = 0;

    logic [7:0] tx    [NB];
    logic [7:0] e_dat [NB];
    logic       e_par [NB];
    logic       e_cor [NB];
    logic       e_unc [NB];

    always #10 clk = ~clk;  // 50 MHz

    line_deframer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .bit_stb(bit_stb),
        .bit_in(bit_in), .byte_vld(byte_vld), .byte_idx(byte_idx),
        .byte_data(byte_data), .par_err(par_err), .ham_cor(ham_cor),
        .ham_unc(ham_unc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Header encoding as given in R6.
    function automatic logic [7:0] hdr_enc(input logic [3:0] d);
        logic [7:0] b;
        b[0] = d[0]; b[2] = d[1]; b[4] = d[2]; b[6] = d[3];
        b[1] = d[0] ^ d[1] ^ d[3];
        b[3] = d[0] ^ d[2] ^ d[3];
        b[5] = d[1] ^ d[2] ^ d[3];
        b[7] = ~(^b[6:0]);
        return b;
    endfunction

    function automatic logic [7:0] txt_enc(input logic [6:0] d);
        return {~(^d), d};
    endfunction

    // Fill tx and expected results; mode 0 clean, 1 single, 2 double errors.
    task automatic build_line(input int mode);
        for (int k = 0; k < NB; k++) begin
            if (k < 2) begin
                logic [3:0] nib = 4'($urandom);
                int p1 = (mode == 1 && k == 0) ? 7 : int'($urandom % 8);
                int p2 = (p1 + 1 + int'($urandom % 7)) % 8;
                logic [7:0] b = hdr_enc(nib);
                if (mode >= 1) b[p1] = ~b[p1];
                if (mode == 2) b[p2] = ~b[p2];
                tx[k]    = b;
                e_dat[k] = (mode == 2) ? {4'b0, b[6], b[4], b[2], b[0]} : {4'b0, nib};
                e_par[k] = 1'b0;
                e_cor[k] = (mode == 1);
                e_unc[k] = (mode == 2);
            end else begin
                logic [7:0] b = txt_enc(7'($urandom));
                if (mode == 0 && k == 2) b = 8'h01;
                if (mode == 0 && k == 3) b = 8'h40;
                if (mode != 0 && ($urandom % 4) == 0) b[$urandom % 8] ^= 1'b1;
                tx[k]    = b;
                e_dat[k] = {1'b0, b[6:0]};
                e_par[k] = ~(^b);
                e_cor[k] = 1'b0;
                e_unc[k] = 1'b0;
            end
        end
    endtask

    task automatic send_bit(input logic b);
        int gap = int'($urandom % 3);
        repeat (gap) begin
            @(negedge clk);
            bit_stb = 1'b0;
            bit_in  = 1'($urandom);  // R12: noise on unstrobed cycles
        end
        @(negedge clk);
        bit_stb = 1'b1;
        bit_in  = b;
    endtask

    // One line: run-in of pre bits, framing code, nbytes payload, tail bits.
    task automatic run_line(input int pre, input int nbytes, input int tail,
                            input int exp_cnt, input string tag);
        @(negedge clk);
        got_cnt    = 0;
        bit_stb    = 1'b0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < pre; i++) send_bit(i % 2 == 0);
        for (int i = 0; i < 8; i++) send_bit(CODE[i]);
        for (int k = 0; k < nbytes; k++)
            for (int j = 0; j < 8; j++) send_bit(tx[k][j]);
        for (int i = 0; i < tail; i++) send_bit(1'($urandom));
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk(got_cnt == exp_cnt, tag, got_cnt, exp_cnt);
    endtask

    // Output monitor: compares every strobed byte with the expected arrays.
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            chk(int'(byte_idx) == got_cnt, "R5 byte_idx order", int'(byte_idx), got_cnt);
            if (got_cnt < NB) begin
                if (got_cnt < 2) begin
                    chk(byte_data == e_dat[got_cnt], "R4 R6 R7 R8 header data",
                        int'(byte_data), int'(e_dat[got_cnt]));
                    chk(ham_cor == e_cor[got_cnt], "R7 ham_cor", int'(ham_cor), int'(e_cor[got_cnt]));
                    chk(ham_unc == e_unc[got_cnt], "R8 ham_unc", int'(ham_unc), int'(e_unc[got_cnt]));
                end else begin
                    chk(byte_data == e_dat[got_cnt], "R4 R9 text data",
                        int'(byte_data), int'(e_dat[got_cnt]));
                    chk(par_err == e_par[got_cnt], "R9 par_err", int'(par_err), int'(e_par[got_cnt]));
                end
            end
            got_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset and deaf before the first line start.
        chk({byte_vld, byte_data, par_err, ham_cor, ham_unc} == '0, "R1 reset outputs",
            int'({byte_vld, byte_data, par_err, ham_cor, ham_unc}), 0);
        got_cnt = 0;
        build_line(0);
        for (int i = 0; i < 16; i++) send_bit(i % 2 == 0);
        for (int i = 0; i < 8; i++) send_bit(CODE[i]);
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 8; j++) send_bit(tx[k][j]);
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk(got_cnt == 0, "R1 no bytes before line_start", got_cnt, 0);

        // R2 R4 R6 R9 R10: clean line, trailing bits ignored.
        build_line(0);
        run_line(16, NB, 24, NB, "R2 R10 byte count clean line");
        // R7: single errors, first one in the parity bit.
        build_line(1);
        run_line(16, NB, 0, NB, "R7 byte count single errors");
        // R8: double errors.
        build_line(2);
        run_line(18, NB, 0, NB, "R8 byte count double errors");
        // R3: last framing bit at strobe 32 is accepted.
        build_line(1);
        run_line(24, NB, 0, NB, "R3 window edge accepted");
        // R3: last framing bit at strobe 34 is rejected.
        build_line(0);
        run_line(26, NB, 0, 0, "R3 late code abandons line");
        // R11: cut a line short, then a fresh line must decode fully.
        build_line(1);
        run_line(20, 10, 0, 10, "R11 partial line");
        build_line(2);
        run_line(22, NB, 0, NB, "R11 line after restart");
        // Random lines.
        for (int n = 0; n < 6; n++) begin
            build_line(int'($urandom % 3));
            run_line(16 + 2 * int'($urandom % 5), NB, 8, NB, "R2 R10 random line count");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule